// File: doc/BRIEF.md
# Delayed-Branch Fetch Control Unit

This block holds the program counter and the fetch sequencing of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it presents a fetch address, captures the returned instruction word into a decode register, and hands the decode-stage instruction on to execute. In decode, a small decoder spots conditional branches and jumps. A dedicated equality comparator judges the two register operands, which arrive on input ports. When a branch is taken, the PC is redirected in that same cycle, so a control instruction does no further work after decode.

Because the decision falls in decode, exactly one instruction after any branch or jump is already in flight. The `delay_mode` input sets what happens to it. With `delay_mode` low, that instruction is squashed into an all-zero bubble, and every branch or jump costs two cycles. With `delay_mode` high, it is an architectural delay slot: it always completes, and only then does fetch go to the target or carry on in sequence. A control instruction placed in a delay slot is undefined.

Top module: `fcu_top`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals `RESET_PC` (default 0), and `ex_valid` and `ex_bubble` are both 0.
- R2: Without control instructions, `fetch_pc` rises by 4 each cycle. The word fetched at address A appears in execute (`ex_valid`=1, `ex_pc`=A, `ex_instr`=that word) two clock edges later, at one instruction per cycle.
- R3: Opcode bits [31:26]=000100 is branch-if-equal. It is taken when the two operands are equal. Its target is its own address + 4 + (sign-extended bits [15:0] shifted left by 2).
- R4: Opcode 000101 is branch-if-not-equal. It uses the same target rule and is taken when the operands differ.
- R5: Opcode 000010 is a jump and is always taken. Its target is {bits [31:28] of its own address + 4, instruction bits [25:0], 2'b00}.
- R6: With `delay_mode`=0, the instruction fetched right after a branch or jump reaches execute as a bubble: `ex_bubble`=1, `ex_valid`=0, `ex_instr`=0. The next real instruction is the target if taken, or the branch address + 4 if not. Each control instruction therefore adds exactly one bubble.
- R7: With `delay_mode`=1, the instruction right after a branch or jump always completes. It is followed by the target if taken, or the branch address + 8 if not. No bubble is ever produced.
- R8: `rs_idx` and `rt_idx` carry bits [25:21] and [20:16] of the instruction now in decode, and the comparator judges `rs_val` against `rt_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_mode | input | 1 | 1: delay-slot policy, 0: squash policy |
| fetch_pc | output | 32 | Instruction fetch address |
| imem_rdata | input | 32 | Instruction word at `fetch_pc`, same cycle |
| rs_idx | output | 5 | First operand register index of decode instruction |
| rt_idx | output | 5 | Second operand register index of decode instruction |
| rs_val | input | 32 | Value of register `rs_idx` |
| rt_val | input | 32 | Value of register `rt_idx` |
| ex_pc | output | 32 | Address of instruction in execute |
| ex_instr | output | 32 | Instruction word in execute (0 for bubble) |
| ex_valid | output | 1 | Execute holds a real instruction |
| ex_bubble | output | 1 | Execute holds a squashed slot |

## Verification
Two things happen on the same clock edge. The decode-stage redirect loads a new PC, and the instruction already fetched behind the branch is either kept or squashed. The bench provokes this with programs that mix taken and not-taken equal and not-equal branches, and jumps backward and forward, some of them landing on further branches. It runs the same program under both policies. A bench-side reference interpreter yields the expected per-cycle execute trace, with bubbles, for each policy. Any slip in either action shows up as a wrong address, a missing or extra bubble, or a wrong word in execute.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JIDX_W  = XLEN - OPC_W;
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BR_NE = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_BR_EQ = 2'd1,
        CK_BR_NE = 2'd2,
        CK_JUMP  = 2'd3
    } ctrl_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
        logic            valid;
        logic            bubble;
    } stage_t;

    typedef struct packed {
        logic [XLEN-1:0] fetch_pc;
        stage_t          id;
        stage_t          ex;
    } fcu_state_t;

endpackage

// File: rtl/fcu_branch_unit.sv
module fcu_branch_unit
    import fcu_pkg::*;
(
    input  logic [XLEN-1:0]  id_pc,
    input  logic [XLEN-1:0]  id_instr,
    input  logic             id_valid,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output logic [REG_W-1:0] rs_idx,
    output logic [REG_W-1:0] rt_idx,
    output logic             is_ctrl,
    output logic             taken,
    output logic [XLEN-1:0]  target
);
    localparam int unsigned RS_LSB = XLEN - OPC_W - REG_W;
    localparam int unsigned RT_LSB = RS_LSB - REG_W;

    logic [OPC_W-1:0]  opc;
    logic [IMM_W-1:0]  imm;
    logic [JIDX_W-1:0] jidx;
    logic [XLEN-1:0]   link;
    logic [XLEN-1:0]   br_tgt;
    logic [XLEN-1:0]   jmp_tgt;
    logic              ops_equal;
    ctrl_kind_e        kind;

    assign opc    = id_instr[XLEN-1 -: OPC_W];
    assign imm    = id_instr[IMM_W-1:0];
    assign jidx   = id_instr[JIDX_W-1:0];
    assign rs_idx = id_instr[RS_LSB +: REG_W];
    assign rt_idx = id_instr[RT_LSB +: REG_W];

    // Dedicated comparator sitting in decode
    assign ops_equal = (rs_val == rt_val);

    always_comb begin
        kind = CK_NONE;
        if (id_valid) begin
            unique case (opc)
                OPC_BR_EQ: kind = CK_BR_EQ;
                OPC_BR_NE: kind = CK_BR_NE;
                OPC_JUMP:  kind = CK_JUMP;
                default:   kind = CK_NONE;
            endcase
        end
    end

    always_comb begin
        link    = id_pc + PC_STEP;
        br_tgt  = link + ({{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} << 2);
        jmp_tgt = {link[XLEN-1 -: (XLEN-JIDX_W-2)], jidx, 2'b00};
    end

    always_comb begin
        is_ctrl = (kind != CK_NONE);
        taken   = 1'b0;
        target  = br_tgt;
        unique case (kind)
            CK_BR_EQ: taken = ops_equal;
            CK_BR_NE: taken = !ops_equal;
            CK_JUMP: begin
                taken  = 1'b1;
                target = jmp_tgt;
            end
            default:  taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcu_next_pc.sv
module fcu_next_pc
    import fcu_pkg::*;
(
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            is_ctrl,
    input  logic            taken,
    input  logic [XLEN-1:0] target,
    input  logic            delay_mode,
    output logic [XLEN-1:0] next_pc,
    output logic            squash_slot
);
    always_comb begin
        squash_slot = 1'b0;
        next_pc     = fetch_pc + PC_STEP;
        if (is_ctrl) begin
            squash_slot = !delay_mode;
            if (taken) begin
                next_pc = target;
            end else if (!delay_mode) begin
                // slot was discarded: fetch the same word again
                next_pc = fetch_pc;
            end
        end
    end

endmodule

// File: rtl/fcu_top.sv
module fcu_top
    import fcu_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        delay_mode,
    output logic [31:0] fetch_pc,
    input  logic [31:0] imem_rdata,
    output logic [4:0]  rs_idx,
    output logic [4:0]  rt_idx,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] ex_pc,
    output logic [31:0] ex_instr,
    output logic        ex_valid,
    output logic        ex_bubble
);
    fcu_state_t      st_d, st_q;
    logic            dec_ctrl;
    logic            dec_taken;
    logic [XLEN-1:0] dec_target;
    logic [XLEN-1:0] nxt_pc;
    logic            squash;

    fcu_branch_unit u_branch (
        .id_pc    (st_q.id.pc),
        .id_instr (st_q.id.instr),
        .id_valid (st_q.id.valid),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .rs_idx   (rs_idx),
        .rt_idx   (rt_idx),
        .is_ctrl  (dec_ctrl),
        .taken    (dec_taken),
        .target   (dec_target)
    );

    fcu_next_pc u_next (
        .fetch_pc    (st_q.fetch_pc),
        .is_ctrl     (dec_ctrl),
        .taken       (dec_taken),
        .target      (dec_target),
        .delay_mode  (delay_mode),
        .next_pc     (nxt_pc),
        .squash_slot (squash)
    );

    always_comb begin
        st_d          = st_q;
        st_d.fetch_pc = nxt_pc;
        st_d.ex       = st_q.id;
        st_d.id.pc    = st_q.fetch_pc;
        if (squash) begin
            st_d.id.instr  = '0;
            st_d.id.valid  = 1'b0;
            st_d.id.bubble = 1'b1;
        end else begin
            st_d.id.instr  = imem_rdata;
            st_d.id.valid  = 1'b1;
            st_d.id.bubble = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.fetch_pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc  = st_q.fetch_pc;
    assign ex_pc     = st_q.ex.pc;
    assign ex_instr  = st_q.ex.instr;
    assign ex_valid  = st_q.ex.valid;
    assign ex_bubble = st_q.ex.bubble;

endmodule

// File: rtl/fcu_checker.sv
module fcu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        delay_mode,
    input logic [31:0] fetch_pc,
    input logic [31:0] ex_instr,
    input logic        ex_valid,
    input logic        ex_bubble,
    input logic        dec_ctrl,
    input logic        dec_taken,
    input logic [31:0] dec_target
);
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_ctrl |=> fetch_pc == $past(fetch_pc) + 32'd4);

    p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ctrl && dec_taken) |=> fetch_pc == $past(dec_target));

    p_bubble_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> (!ex_valid && ex_instr == 32'd0));

    p_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ctrl && !delay_mode) |=> ##1 ex_bubble);

    p_refetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ctrl && !dec_taken && !delay_mode) |=> fetch_pc == $past(fetch_pc));

    p_slot_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ctrl && delay_mode) |=> ##1 (ex_valid && !ex_bubble));

endmodule

bind fcu_top fcu_checker u_fcu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .delay_mode (delay_mode),
    .fetch_pc   (fetch_pc),
    .ex_instr   (ex_instr),
    .ex_valid   (ex_valid),
    .ex_bubble  (ex_bubble),
    .dec_ctrl   (dec_ctrl),
    .dec_taken  (dec_taken),
    .dec_target (dec_target)
);

// File: tb/fcu_top_tb_top.sv
module fcu_top_tb_top;

    localparam logic [31:0] BUB = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        delay_mode = 1'b0;
    logic [31:0] fetch_pc;
    logic [31:0] imem_rdata;
    logic [4:0]  rs_idx, rt_idx;
    logic [31:0] rs_val, rt_val;
    logic [31:0] ex_pc, ex_instr;
    logic        ex_valid, ex_bubble;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    int unsigned last_bubbles = 0;
    bit          done = 1'b0;

    logic [31:0] mem [32];
    logic [31:0] exp_tr [64];

    always #10 clk = ~clk;   // 50 MHz

    assign imem_rdata = mem[fetch_pc[6:2]];
    assign rs_val = {27'd0, rs_idx} >> 1;
    assign rt_val = {27'd0, rt_idx} >> 1;

    fcu_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_mode (delay_mode),
        .fetch_pc   (fetch_pc),
        .imem_rdata (imem_rdata),
        .rs_idx     (rs_idx),
        .rt_idx     (rt_idx),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .ex_pc      (ex_pc),
        .ex_instr   (ex_instr),
        .ex_valid   (ex_valid),
        .ex_bubble  (ex_bubble)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(input int idx);
        return {6'b000010, 26'(idx)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic fill_plain();
        for (int i = 0; i < 32; i++) mem[i] = enc_i(6'h08, 1, 2, i);
    endtask

    // Reference interpreter, from the requirement text
    task automatic build_ref(input bit dmode, input int n);
        logic [31:0] pc, w, tgt, a, b;
        bit ctrl, tk;
        int k;
        pc = 32'd0;
        k = 0;
        while (k < n) begin
            exp_tr[k] = pc; k++;
            w = mem[pc[6:2]];
            a = {27'd0, w[25:21]} >> 1;
            b = {27'd0, w[20:16]} >> 1;
            ctrl = 1'b0; tk = 1'b0;
            tgt = pc + 32'd4 + ({{16{w[15]}}, w[15:0]} << 2);
            if (w[31:26] == 6'b000100) begin ctrl = 1'b1; tk = (a == b); end
            if (w[31:26] == 6'b000101) begin ctrl = 1'b1; tk = (a != b); end
            if (w[31:26] == 6'b000010) begin
                ctrl = 1'b1; tk = 1'b1;
                tgt = {pc[31:28] + 4'd0, w[25:0], 2'b00};
            end
            if (!ctrl) pc = pc + 32'd4;
            else if (dmode) begin
                if (k < n) begin exp_tr[k] = pc + 32'd4; k++; end
                pc = tk ? tgt : pc + 32'd8;
            end else begin
                if (k < n) begin exp_tr[k] = BUB; k++; end
                pc = tk ? tgt : pc + 32'd4;
            end
        end
    endtask

    task automatic do_reset(input bit dmode);
        rst_n = 1'b0;
        delay_mode = dmode;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_trace(input bit dmode, input int n, input string req);
        int guard;
        build_ref(dmode, n);
        do_reset(dmode);
        guard = 0;
        @(negedge clk);
        while (!ex_valid && guard < 4) begin @(negedge clk); guard++; end
        last_bubbles = 0;
        for (int k = 0; k < n; k++) begin
            if (exp_tr[k] == BUB) begin
                check({req, " bubble flag"}, {31'd0, ex_bubble}, 32'd1);
                check({req, " bubble word"}, ex_instr, 32'd0);
            end else begin
                check({req, " pc"}, ex_valid ? ex_pc : BUB, exp_tr[k]);
                check({req, " word"}, ex_instr, mem[exp_tr[k][6:2]]);
            end
            if (ex_bubble) last_bubbles++;
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        fill_plain();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 fetch_pc", fetch_pc, 32'd0);
        check("R1 ex_valid", {31'd0, ex_valid}, 32'd0);
        check("R1 ex_bubble", {31'd0, ex_bubble}, 32'd0);
    endtask

    task automatic test_sequential();
        logic [31:0] p0;
        fill_plain();
        do_reset(1'b0);
        @(negedge clk);
        p0 = fetch_pc;
        @(negedge clk);
        check("R2 pc step", fetch_pc, p0 + 32'd4);
        check("R2 first in execute", ex_pc, 32'd0);
        run_trace(1'b0, 12, "R2");
    endtask

    task automatic test_reg_index();
        for (int i = 0; i < 32; i++) mem[i] = enc_i(6'h08, i + 1, i + 9, 0);
        do_reset(1'b0);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check("R8 rs_idx", {27'd0, rs_idx}, 32'(j + 1));
            check("R8 rt_idx", {27'd0, rt_idx}, 32'(j + 9));
        end
    endtask

    task automatic load_mix();
        fill_plain();
        mem[2]  = enc_i(6'b000100, 2, 3, 3);     // equal operands, taken
        mem[6]  = enc_i(6'b000100, 2, 4, 5);     // not equal, not taken
        mem[8]  = enc_i(6'b000101, 6, 7, 2);     // equal, not taken
        mem[10] = enc_j(16);                     // jump
        mem[17] = enc_i(6'b000101, 1, 9, -15);   // differ, taken backward
    endtask

    task automatic test_mix_stall();
        load_mix();
        run_trace(1'b0, 40, "R3 R4 R5 R6 stall");
    endtask

    task automatic test_mix_delay();
        load_mix();
        run_trace(1'b1, 40, "R3 R4 R5 R7 delay");
        check("R7 no bubbles", 32'(last_bubbles), 32'd0);
    endtask

    task automatic test_cost();
        fill_plain();
        mem[2] = enc_i(6'b000100, 2, 4, 7);      // not taken
        mem[5] = enc_i(6'b000101, 6, 7, 7);      // not taken
        run_trace(1'b1, 10, "R7 cost");
        check("R7 not-taken cost", 32'(last_bubbles), 32'd0);
        run_trace(1'b0, 12, "R6 cost");
        check("R6 one bubble per branch", 32'(last_bubbles), 32'd2);
    endtask

    initial begin
        test_reset();
        test_sequential();
        test_reg_index();
        test_mix_stall();
        test_mix_delay();
        test_cost();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule